// File: doc/BRIEF.md
# Corrected error syndrome counter

This block holds a single error record for corrected faults reported by memory arrays in several cache and TLB units. Each report names the reporting unit and the place in the array where the fault was seen: array code, index, subarray, bank, subbank and way. The first corrected fault after reset, or after software has cleared the record, is stored as the recorded syndrome.

Each later report is compared against the stored syndrome. A report that equals it counts as a repeat. A report that differs counts as other and leaves the stored syndrome unchanged. Each class has a 7-bit counter and a sticky overflow flag. While the interrupt enable is high and either flag is set, the block drives a fault-handling interrupt.

Software reads and writes the whole record as one packed 64-bit word. It uses the write to seed the counters, to clear the flags and to reset the capture state.

Top module: `ce_syn_record`

## Requirements
- R1: After a synchronous active-low reset, record bits 63:32 (both counters and both overflow flags) read zero, no syndrome is held, and `fault_irq` is low.
- R2: The read word is laid out as follows. Way is at 31:28, subbank at 25, bank at 24:23, subarray at 22:19, index at 18:6, array at 5:4 and unit at 3:0. The repeat count is at 38:32 with its overflow flag at 39. The other count is at 46:40 with its overflow flag at 47. Bits 63:48 and 27:26 always read zero. Unit codes are one-hot: 1000 for the L2 cache, 0100 for the L1 data cache, 0010 for the L2 TLB and 0001 for the L1 instruction cache.
- R3: When no syndrome is held, an accepted report (`err_valid` high) stores its fields as the syndrome and adds one to the repeat count.
- R4: When a syndrome is held, a report whose fields all equal it adds one to the repeat count. A report that differs in any field adds one to the other count and leaves the stored syndrome unchanged.
- R5: When a counter at 127 is incremented, it wraps to 0 and sets its overflow flag. A set flag stays set until software writes 0 to its bit.
- R6: `fault_irq` is high exactly when `irq_en` is high and at least one overflow flag is set. It follows `irq_en` in the same cycle.
- R7: A software write (`reg_wr` high) loads the syndrome and both counts from `reg_wdata`. Writing 0 to an overflow bit clears that flag. Writing 1 leaves the flag as it was.
- R8: A write with all syndrome fields zero marks the record empty, so the next report is handled as the first one (R3). A write with any syndrome field nonzero marks the syndrome as held.
- R9: When a software write and a report arrive in the same cycle, the write takes effect and the report is dropped.
- R10: In a cycle with neither `err_valid` nor `reg_wr`, the whole record is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_valid | input | 1 | A corrected-error report is present this cycle |
| err_unit | input | 4 | One-hot code of the reporting unit |
| err_array | input | 2 | Array code within the unit |
| err_index | input | 13 | Array index of the fault |
| err_subarray | input | 4 | Subarray / word / tag-way selector |
| err_bank | input | 2 | Bank selector |
| err_subbank | input | 1 | Subbank selector |
| err_way | input | 4 | Way or RAM selector |
| irq_en | input | 1 | Corrected-error interrupt enable |
| reg_wr | input | 1 | Software write strobe for the record |
| reg_wdata | input | 64 | Software write data, in the R2 layout |
| reg_rdata | output | 64 | Current packed record, in the R2 layout |
| fault_irq | output | 1 | Fault-handling interrupt |

## Verification
A software write and an error report can both arrive in the same cycle. The bench provokes this by raising `reg_wr` in the same cycle as `err_valid`, with a report that would otherwise add to the other count. It then reads back both counts and the syndrome and expects exactly the written values. Counter wrap and software flag clearing are also checked against each other. A counter is driven across 127 to set its flag, and a later write clears only one of the two set flags, with `fault_irq` checked after each step.

// File: rtl/ce_rec_pkg.sv
// Package: shared widths, record bit positions and the syndrome type.
// Assumes a fixed 64-bit record whose field positions software decodes.
package ce_rec_pkg;
    localparam int UNIT_W      = 4;
    localparam int ARRAY_W     = 2;
    localparam int INDEX_W     = 13;
    localparam int SUBARR_W    = 4;
    localparam int BANK_W      = 2;
    localparam int WAY_W       = 4;
    localparam int CNT_W       = 7;
    localparam int REC_W       = 64;
    localparam int SYN_WORD_W  = 32;

    localparam int UNIT_LSB    = 0;
    localparam int ARRAY_LSB   = UNIT_LSB + UNIT_W;
    localparam int INDEX_LSB   = ARRAY_LSB + ARRAY_W;
    localparam int SUBARR_LSB  = INDEX_LSB + INDEX_W;
    localparam int BANK_LSB    = SUBARR_LSB + SUBARR_W;
    localparam int SUBBANK_BIT = BANK_LSB + BANK_W;
    localparam int WAY_LSB     = 28;
    localparam int REP_LSB     = SYN_WORD_W;
    localparam int OTH_LSB     = REP_LSB + CNT_W + 1;

    // Class of an accepted report; the value is the counter slot.
    typedef enum logic {
        CLS_REPEAT = 1'b0,
        CLS_OTHER  = 1'b1
    } cls_e;
    localparam int NUM_CLS = 2;

    typedef struct packed {
        logic [WAY_W-1:0]    way;
        logic                subbank;
        logic [BANK_W-1:0]   bank;
        logic [SUBARR_W-1:0] subarr;
        logic [INDEX_W-1:0]  index;
        logic [ARRAY_W-1:0]  arr;
        logic [UNIT_W-1:0]   unit;
    } syn_t;

    // Place syndrome fields into the low record word, reserved bits zero.
    function automatic logic [SYN_WORD_W-1:0] syn_to_word(syn_t s);
        logic [SYN_WORD_W-1:0] w;
        w = '0;
        w[UNIT_LSB   +: UNIT_W]   = s.unit;
        w[ARRAY_LSB  +: ARRAY_W]  = s.arr;
        w[INDEX_LSB  +: INDEX_W]  = s.index;
        w[SUBARR_LSB +: SUBARR_W] = s.subarr;
        w[BANK_LSB   +: BANK_W]   = s.bank;
        w[SUBBANK_BIT]            = s.subbank;
        w[WAY_LSB    +: WAY_W]    = s.way;
        return w;
    endfunction

    // Extract syndrome fields from the low record word.
    function automatic syn_t word_to_syn(logic [SYN_WORD_W-1:0] w);
        syn_t s;
        s.unit    = w[UNIT_LSB   +: UNIT_W];
        s.arr     = w[ARRAY_LSB  +: ARRAY_W];
        s.index   = w[INDEX_LSB  +: INDEX_W];
        s.subarr  = w[SUBARR_LSB +: SUBARR_W];
        s.bank    = w[BANK_LSB   +: BANK_W];
        s.subbank = w[SUBBANK_BIT];
        s.way     = w[WAY_LSB    +: WAY_W];
        return s;
    endfunction
endpackage

// File: rtl/ce_syn_store.sv
// Syndrome store: holds the recorded syndrome and a held flag, and reports
// whether the incoming syndrome equals the stored one.
// Assumes capture is only raised while no syndrome is held; a software
// write overrides capture in the same cycle.
module ce_syn_store
    import ce_rec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic sw_wr,
    input  syn_t err_syn,
    input  syn_t sw_syn,
    output syn_t rec_syn,
    output logic held,
    output logic matched
);

    // Held flag: set by first capture, rewritten by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
        end else if (sw_wr) begin
            held <= (sw_syn != '0);
        end else if (capture) begin
            held <= 1'b1;
        end
    end

    // Syndrome fields: no reset value; loaded by software or first capture.
    always_ff @(posedge clk) begin
        if (sw_wr) begin
            rec_syn <= sw_syn;
        end else if (capture) begin
            rec_syn <= err_syn;
        end
    end

    // Match only counts once a syndrome is held.
    always_comb begin
        matched = held && (err_syn == rec_syn);
    end

    AST_SYN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        held && !sw_wr |=> $stable(rec_syn)); // R4
    AST_FIRST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        capture && !sw_wr |=> held && rec_syn == $past(err_syn)); // R3

endmodule

// File: rtl/ce_evt_counter.sv
// Event counter: a wrapping counter with a sticky overflow flag.
// Assumes software load has priority over increment; a software write of
// 1 to the flag keeps it, a write of 0 clears it.
module ce_evt_counter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         sw_wr,
    input  logic [W-1:0] sw_cnt,
    input  logic         sw_ovf,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    localparam logic [W-1:0] CNT_MAX = '1;
    localparam logic [W-1:0] CNT_ONE = W'(1);

    // Count and flag update: software load, else increment with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (sw_wr) begin
            cnt <= sw_cnt;
            ovf <= ovf & sw_ovf;
        end else if (inc) begin
            cnt <= cnt + CNT_ONE;
            if (cnt == CNT_MAX) begin
                ovf <= 1'b1;
            end
        end
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !sw_wr |=> ovf); // R5
    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !sw_wr && cnt == CNT_MAX |=> ovf && cnt == '0); // R5
    AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr |=> cnt == $past(sw_cnt)); // R9
    AST_SW_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr && !ovf |=> !ovf); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !inc && !sw_wr |=> $stable(cnt) && $stable(ovf)); // R10

endmodule

// File: rtl/ce_syn_record.sv
// Corrected error record: classifies each report as repeat or other against
// the stored syndrome, counts both classes, raises the fault interrupt on
// overflow and exposes the packed 64-bit record for software.
// Assumes at most one report per cycle; a software write wins over a report.
module ce_syn_record
    import ce_rec_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                err_valid,
    input  logic [UNIT_W-1:0]   err_unit,
    input  logic [ARRAY_W-1:0]  err_array,
    input  logic [INDEX_W-1:0]  err_index,
    input  logic [SUBARR_W-1:0] err_subarray,
    input  logic [BANK_W-1:0]   err_bank,
    input  logic                err_subbank,
    input  logic [WAY_W-1:0]    err_way,
    input  logic                irq_en,
    input  logic                reg_wr,
    input  logic [REC_W-1:0]    reg_wdata,
    output logic [REC_W-1:0]    reg_rdata,
    output logic                fault_irq
);

    syn_t               err_syn;
    syn_t               sw_syn;
    syn_t               rec_syn;
    logic               held;
    logic               matched;
    logic               capture;
    logic [NUM_CLS-1:0] cls_inc;
    logic [CNT_W-1:0]   cnt_q [NUM_CLS];
    logic [NUM_CLS-1:0] ovf_q;
    logic               unused_wbits;

    assign unused_wbits = ^{reg_wdata[REC_W-1:OTH_LSB+CNT_W+1],
                            reg_wdata[WAY_LSB-1:SUBBANK_BIT+1]};

    // Gather report fields and decode the software syndrome.
    always_comb begin
        err_syn.unit    = err_unit;
        err_syn.arr     = err_array;
        err_syn.index   = err_index;
        err_syn.subarr  = err_subarray;
        err_syn.bank    = err_bank;
        err_syn.subbank = err_subbank;
        err_syn.way     = err_way;
        sw_syn          = word_to_syn(reg_wdata[SYN_WORD_W-1:0]);
    end

    // Classify the report: first or matching -> repeat, else other.
    always_comb begin
        capture             = err_valid && !held;
        cls_inc             = '0;
        cls_inc[CLS_REPEAT] = err_valid && (!held || matched);
        cls_inc[CLS_OTHER]  = err_valid && held && !matched;
    end

    ce_syn_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .sw_wr   (reg_wr),
        .err_syn (err_syn),
        .sw_syn  (sw_syn),
        .rec_syn (rec_syn),
        .held    (held),
        .matched (matched)
    );

    for (genvar g = 0; g < NUM_CLS; g++) begin : g_cls
        localparam int LSB  = (g == int'(CLS_REPEAT)) ? REP_LSB : OTH_LSB;
        localparam int OBIT = LSB + CNT_W;
        ce_evt_counter #(.W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc    (cls_inc[g]),
            .sw_wr  (reg_wr),
            .sw_cnt (reg_wdata[LSB +: CNT_W]),
            .sw_ovf (reg_wdata[OBIT]),
            .cnt    (cnt_q[g]),
            .ovf    (ovf_q[g])
        );
    end

    // Pack the record word; reserved bits read zero.
    always_comb begin
        reg_rdata                         = '0;
        reg_rdata[SYN_WORD_W-1:0]         = syn_to_word(rec_syn);
        reg_rdata[REP_LSB +: CNT_W]       = cnt_q[CLS_REPEAT];
        reg_rdata[REP_LSB + CNT_W]        = ovf_q[CLS_REPEAT];
        reg_rdata[OTH_LSB +: CNT_W]       = cnt_q[CLS_OTHER];
        reg_rdata[OTH_LSB + CNT_W]        = ovf_q[CLS_OTHER];
    end

    // Interrupt: enabled and any overflow flag set.
    always_comb begin
        fault_irq = irq_en && (|ovf_q);
    end

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        fault_irq |-> (reg_rdata[REP_LSB + CNT_W] || reg_rdata[OTH_LSB + CNT_W])); // R6
    AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid && !reg_wr |=> !$stable(reg_rdata[OTH_LSB + CNT_W:REP_LSB])); // R4
    AST_HELD_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid && !reg_wr |=> held); // R3

endmodule

// File: tb/sim_ce_syn_record.sv
`timescale 1ns/1ps
module sim_ce_syn_record;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        err_valid = 1'b0;
    logic [31:0] err_word = '0;
    logic        irq_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        fault_irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // Build a low record word from fields, per the R2 layout.
    function automatic logic [31:0] mk(input logic [3:0] unit, input logic [1:0] arr,
                                       input logic [12:0] idx, input logic [3:0] sub,
                                       input logic [1:0] bank, input logic sbk,
                                       input logic [3:0] way);
        return {way, 2'b00, sbk, bank, sub, idx, arr, unit};
    endfunction

    localparam logic [31:0] SA = mk(4'b1000, 2'd1, 13'h123, 4'd3, 2'd1, 1'b0, 4'd5);
    localparam logic [31:0] SB = mk(4'b0100, 2'd1, 13'h123, 4'd3, 2'd1, 1'b0, 4'd5);
    localparam logic [31:0] SC = mk(4'b1000, 2'd1, 13'h124, 4'd3, 2'd1, 1'b0, 4'd5);
    localparam logic [31:0] SD = mk(4'b1000, 2'd1, 13'h123, 4'd3, 2'd1, 1'b0, 4'd6);
    localparam logic [31:0] SE = mk(4'b0010, 2'd1, 13'h123, 4'd3, 2'd1, 1'b1, 4'd5);
    localparam logic [31:0] SF = mk(4'b1000, 2'd1, 13'h123, 4'd3, 2'd2, 1'b0, 4'd5);

    localparam int NV = 9;
    localparam logic [31:0] VSYN [NV] = '{SA, SA, SB, SC, SA, SD, SE, SF, SA};
    localparam int          VREP [NV] = '{1, 2, 2, 2, 3, 3, 3, 3, 4};
    localparam int          VOTH [NV] = '{0, 0, 1, 2, 2, 3, 4, 5, 5};

    ce_syn_record u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .err_valid    (err_valid),
        .err_unit     (err_word[3:0]),
        .err_array    (err_word[5:4]),
        .err_index    (err_word[18:6]),
        .err_subarray (err_word[22:19]),
        .err_bank     (err_word[24:23]),
        .err_subbank  (err_word[25]),
        .err_way      (err_word[31:28]),
        .irq_en       (irq_en),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .fault_irq    (fault_irq)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // One report, applied for one edge; result visible at the next negedge.
    task automatic send_err(input logic [31:0] w);
        @(negedge clk);
        err_word  = w;
        err_valid = 1'b1;
        @(negedge clk);
        err_valid = 1'b0;
    endtask

    // One software write, optionally with a report in the same cycle.
    task automatic write_reg(input logic [63:0] d, input bit with_err, input logic [31:0] w);
        @(negedge clk);
        reg_wdata = d;
        reg_wr    = 1'b1;
        err_word  = w;
        err_valid = with_err;
        @(negedge clk);
        reg_wr    = 1'b0;
        err_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 counters", {32'h0, reg_rdata[63:32]}, 64'h0);
        chk("R1 irq", {63'h0, fault_irq}, 64'h0);

        // R3 / R4: vector table of reports
        for (int i = 0; i < NV; i++) begin
            send_err(VSYN[i]);
            chk(i == 0 ? "R3 first count" : "R4 class count",
                {48'h0, reg_rdata[47:32]},
                {48'h0, 1'b0, 7'(VOTH[i]), 1'b0, 7'(VREP[i])});
            chk(i == 0 ? "R3 syndrome" : "R4 syndrome kept",
                {32'h0, reg_rdata[31:0]}, {32'h0, SA});
        end

        // R10: idle cycles change nothing
        snap = reg_rdata;
        repeat (3) @(negedge clk);
        chk("R10 idle", reg_rdata, snap);

        // R7 / R2: write loads fields, 1 to a flag sets nothing, reserved bits zero
        write_reg({16'hFFFF, 1'b1, 7'd127, 1'b1, 7'd126, SA | 32'h0C00_0000}, 1'b0, '0);
        chk("R7 R2 write", reg_rdata, {16'h0, 1'b0, 7'd127, 1'b0, 7'd126, SA});
        chk("R6 irq off", {63'h0, fault_irq}, 64'h0);

        // R5: repeat counter wrap
        send_err(SA);
        chk("R5 at max", {48'h0, reg_rdata[47:32]}, {48'h0, 16'h7F7F});
        send_err(SA);
        chk("R5 wrap rep", {48'h0, reg_rdata[47:32]}, {48'h0, 16'h7F80});
        chk("R6 enable low", {63'h0, fault_irq}, 64'h0);
        irq_en = 1'b1;
        @(negedge clk);
        chk("R6 enable high", {63'h0, fault_irq}, 64'h1);
        send_err(SB);
        chk("R5 wrap oth", {48'h0, reg_rdata[47:32]}, {48'h0, 16'h8080});
        @(negedge clk);
        chk("R5 sticky", {48'h0, reg_rdata[47:32]}, {48'h0, 16'h8080});

        // R7: clear only repeat flag
        write_reg({16'h0, 1'b1, 7'd0, 1'b0, 7'd0, SA}, 1'b0, '0);
        chk("R7 clear one", {48'h0, reg_rdata[47:32]}, {48'h0, 16'h8000});
        chk("R6 one flag", {63'h0, fault_irq}, 64'h1);

        // R9: write and report in the same cycle
        write_reg({16'h0, 1'b0, 7'd6, 1'b0, 7'd5, SA}, 1'b1, SB);
        chk("R9 counts", {48'h0, reg_rdata[47:32]}, {48'h0, 16'h0605});
        chk("R9 syndrome", {32'h0, reg_rdata[31:0]}, {32'h0, SA});
        chk("R6 no flag", {63'h0, fault_irq}, 64'h0);

        // R8: zero syndrome write empties the record
        write_reg(64'h0, 1'b0, '0);
        send_err(SE);
        chk("R8 recapture", reg_rdata, {32'h0000_0001, SE});
        send_err(SE);
        chk("R8 then repeat", {48'h0, reg_rdata[47:32]}, {48'h0, 16'h0002});

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule